// File: doc/BRIEF.md
# Segment Base-Limit Translation Unit

This block turns a logical address into a 32-bit linear address. The logical address is a 16-bit segment selector and a 32-bit offset. The upper selector bits pick one entry of a small on-chip descriptor table. Each entry holds a base, a limit, a present flag, a code/data kind, a kind-dependent permission bit and a user-access bit. The linear address is the entry's base plus the offset. Every request is checked against the limit, the access type and the current privilege mode. A failed check raises a fault and suppresses the address.

A controller fills the table through a simple write port. The execution side presents one request per cycle. Translation and checking are combinational. The outcome, made of a valid flag, a fault flag and the linear address, is registered and appears one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_lin are 0, and every table entry is absent, so any request faults until entries are written.
- R2: A request presented with req_valid=1 produces rsp_valid=1 exactly one cycle later. A cycle without a request produces rsp_valid=0 and rsp_fault=0 in the following cycle.
- R3: A request that does not fault returns rsp_lin = base + offset, modulo 2^32 (the sum wraps).
- R4: The offset may equal the limit. Any offset greater than the limit faults.
- R5: A selector whose index field req_sel[15:3] is 0 always faults, even when entry 0 has been written. Selector bits [2:0] take no part in translation.
- R6: An index of 8 or more faults, and so does an index whose entry is not present.
- R7: Access codes are 0 read, 1 write, 2 execute and 3 reserved. A code entry (kind bit 1) allows execute, and allows read only when its permission bit is 1. Write to a code entry always faults.
- R8: A data entry (kind bit 0) always allows read and allows write only when its permission bit is 1. Execute faults on a data entry, and access code 3 faults on any entry.
- R9: A request with req_user=1 faults on an entry whose user bit is 0. A request with req_user=0 may use any entry that passes the other checks.
- R10: Whenever rsp_fault is 1, rsp_lin is 0.
- R11: A table write at one clock edge is used by every request presented in a later cycle. Rewriting an entry replaces all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Entry written |
| cfg_base | input | 32 | Segment base |
| cfg_limit | input | 32 | Highest legal offset |
| cfg_present | input | 1 | Entry present |
| cfg_code | input | 1 | 1 = code entry, 0 = data entry |
| cfg_perm | input | 1 | Code: readable; data: writable |
| cfg_user | input | 1 | Entry open to user mode |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset in segment |
| req_acc | input | 2 | Access type code |
| req_user | input | 1 | Requester is in user mode |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 1 | Access rejected |
| rsp_lin | output | 32 | Linear address, 0 on fault |

## Verification
The main function is tried with a table of requests against entries that differ in kind, permission bit, user bit and limit. For each entry there are accesses that must pass and accesses that must be rejected. Offsets set exactly at the limit and one past it separate an inclusive limit check from an exclusive one. A base near the top of the address space shows whether the sum wraps. Selectors with non-zero low bits, the null index, an index past the table and an absent entry each isolate one decode path. Reserved access codes and user-mode requests to kernel entries separate the type check from the privilege check.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_AW = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } seg_acc_e;

  typedef struct packed {
    logic              present;
    logic              is_code;
    logic              perm;
    logic              user_ok;
    logic [SEG_AW-1:0] base;
    logic [SEG_AW-1:0] limit;
  } seg_desc_t;

  function automatic logic [SEG_AW-1:0] seg_linear(input logic [SEG_AW-1:0] base,
                                                   input logic [SEG_AW-1:0] off);
    return base + off;
  endfunction

  function automatic logic seg_type_ok(input seg_desc_t d, input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = d.is_code ? d.perm : 1'b1;
      ACC_WRITE: ok = d.is_code ? 1'b0 : d.perm;
      ACC_EXEC:  ok = d.is_code;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic seg_priv_ok(input seg_desc_t d, input logic user);
    return !user || d.user_ok;
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc
);
  seg_desc_t tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        tbl[g] <= wr_desc;
    end
  end

  assign rd_desc = tbl[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SEL_W = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int SIDX_W = SEL_W - 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [SEG_AW-1:0] off,
  input  logic [1:0]        acc,
  input  logic              user,
  input  seg_desc_t         desc,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              idx_null,
  output logic              idx_range,
  output logic              absent,
  output logic              limit_over,
  output logic              type_bad,
  output logic              priv_bad,
  output logic              fault,
  output logic [SEG_AW-1:0] lin
);
  logic [SEL_W-1:0]  sel_sh;
  logic [SIDX_W-1:0] sidx;

  assign sel_sh     = sel >> 3;
  assign sidx       = sel_sh[SIDX_W-1:0];
  assign tbl_idx    = sidx[IDX_W-1:0];
  assign idx_null   = (sidx == '0);
  assign idx_range  = (sidx >= SIDX_W'(ENTRIES));
  assign absent     = !desc.present;
  assign limit_over = (off > desc.limit);
  assign type_bad   = !seg_type_ok(desc, acc);
  assign priv_bad   = !seg_priv_ok(desc, user);
  assign fault      = idx_null | idx_range | absent | limit_over | type_bad | priv_bad;
  assign lin        = seg_linear(desc.base, off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SEL_W = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SEG_AW-1:0] cfg_base,
  input  logic [SEG_AW-1:0] cfg_limit,
  input  logic              cfg_present,
  input  logic              cfg_code,
  input  logic              cfg_perm,
  input  logic              cfg_user,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [SEG_AW-1:0] req_off,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [SEG_AW-1:0] rsp_lin
);
  seg_desc_t         wr_desc, rd_desc;
  logic [IDX_W-1:0]  w_idx;
  logic              w_null, w_range, w_absent, w_limit_over, w_type_bad, w_priv_bad;
  logic              w_fault;
  logic [SEG_AW-1:0] w_lin;

  always_comb begin
    wr_desc         = '0;
    wr_desc.present = cfg_present;
    wr_desc.is_code = cfg_code;
    wr_desc.perm    = cfg_perm;
    wr_desc.user_ok = cfg_user;
    wr_desc.base    = cfg_base;
    wr_desc.limit   = cfg_limit;
  end

  seg_desc_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_desc(wr_desc),
    .rd_idx(w_idx), .rd_desc(rd_desc)
  );

  seg_check #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_chk_logic (
    .sel(req_sel), .off(req_off), .acc(req_acc), .user(req_user), .desc(rd_desc),
    .tbl_idx(w_idx), .idx_null(w_null), .idx_range(w_range), .absent(w_absent),
    .limit_over(w_limit_over), .type_bad(w_type_bad), .priv_bad(w_priv_bad),
    .fault(w_fault), .lin(w_lin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_lin   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && w_fault;
      rsp_lin   <= (req_valid && !w_fault) ? w_lin : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEL_W-1:0] req_sel,
  input logic             req_user,
  input logic             limit_over,
  input logic             priv_bad,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [31:0]      rsp_lin
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));
  p_limit_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && limit_over) |=> rsp_fault);
  p_null_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_sel >> 3) == '0) |=> rsp_fault);
  p_user_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && priv_bad) |=> rsp_fault);
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_lin == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.SEL_W(SEL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
  .req_user(req_user), .limit_over(w_limit_over), .priv_bad(w_priv_bad),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic        cfg_present = 1'b0, cfg_code = 1'b0, cfg_perm = 1'b0, cfg_user = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_lin;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate uut (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [15:0] sel;
    logic [31:0] off;
    logic [1:0]  acc;
    logic        user;
    logic        flt;
    logic [31:0] lin;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  16'h0008, 32'h0000_0010, 2'd0, 1'b0, 1'b0, 32'h1000_0010}, // R3 R7 code read
    '{4'd4,  16'h0008, 32'h0000_FFFF, 2'd2, 1'b0, 1'b0, 32'h1000_FFFF}, // R4 at limit
    '{4'd4,  16'h0008, 32'h0001_0000, 2'd2, 1'b0, 1'b1, 32'h0},         // R4 past limit
    '{4'd7,  16'h0008, 32'h0000_0000, 2'd1, 1'b0, 1'b1, 32'h0},         // R7 write code
    '{4'd9,  16'h0008, 32'h0000_0000, 2'd0, 1'b1, 1'b1, 32'h0},         // R9 user on kernel
    '{4'd8,  16'h0010, 32'h0000_0FFF, 2'd1, 1'b1, 1'b0, 32'h2000_0FFF}, // R8 data write
    '{4'd8,  16'h0010, 32'h0000_0000, 2'd2, 1'b1, 1'b1, 32'h0},         // R8 exec data
    '{4'd5,  16'h0017, 32'h0000_0004, 2'd0, 1'b1, 1'b0, 32'h2000_0004}, // R5 low bits ignored
    '{4'd8,  16'h0018, 32'h0000_0000, 2'd1, 1'b0, 1'b1, 32'h0},         // R8 read-only data
    '{4'd3,  16'h0018, 32'h0000_1800, 2'd0, 1'b1, 1'b0, 32'h0000_0800}, // R3 wrap
    '{4'd7,  16'h0020, 32'h0000_0000, 2'd0, 1'b1, 1'b1, 32'h0},         // R7 exec-only read
    '{4'd7,  16'h0020, 32'h0000_0080, 2'd2, 1'b1, 1'b0, 32'h0000_0480}, // R7 exec
    '{4'd6,  16'h0028, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 32'h0},         // R6 absent
    '{4'd6,  16'h0040, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 32'h0},         // R6 index 8
    '{4'd5,  16'h0003, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 32'h0},         // R5 null
    '{4'd8,  16'h0010, 32'h0000_0000, 2'd3, 1'b1, 1'b1, 32'h0}          // R8 reserved code
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] base, input logic [31:0] lim,
                    input logic pres, input logic code, input logic perm, input logic usr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_limit = lim;
    cfg_present = pres; cfg_code = code; cfg_perm = perm; cfg_user = usr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rq_go(input logic [15:0] sel, input logic [31:0] off,
                       input logic [1:0] acc, input logic usr);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_off = off; req_acc = acc; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "valid after reset", 32'(rsp_valid), 32'd0);
    chk(1, "fault after reset", 32'(rsp_fault), 32'd0);
    chk(1, "lin after reset", rsp_lin, 32'd0);
    rst_n = 1'b1;
    rq_go(16'h0008, 32'h0, 2'd0, 1'b0);
    chk(1, "empty table faults", 32'(rsp_fault), 32'd1);
    chk(2, "valid one cycle later", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk(2, "valid drops when idle", 32'(rsp_valid), 32'd0);
    chk(2, "fault drops when idle", 32'(rsp_fault), 32'd0);

    wr(3'd0, 32'h5000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    wr(3'd1, 32'h1000_0000, 32'h0000_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    wr(3'd2, 32'h2000_0000, 32'h0000_0FFF, 1'b1, 1'b0, 1'b1, 1'b1);
    wr(3'd3, 32'hFFFF_F000, 32'h0000_1FFF, 1'b1, 1'b0, 1'b0, 1'b1);
    wr(3'd4, 32'h0000_0400, 32'h0000_00FF, 1'b1, 1'b1, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      rq_go(VECS[i].sel, VECS[i].off, VECS[i].acc, VECS[i].user);
      chk(int'(VECS[i].rq), $sformatf("vec %0d fault", i), 32'(rsp_fault), 32'(VECS[i].flt));
      chk(int'(VECS[i].rq), $sformatf("vec %0d lin", i), rsp_lin, VECS[i].lin);
      if (VECS[i].flt) chk(10, $sformatf("vec %0d lin zero on fault", i), rsp_lin, 32'd0);
    end

    // R11: new entry used in the next cycle, rewrite replaces fields
    wr(3'd6, 32'h0000_8000, 32'h0000_0100, 1'b1, 1'b0, 1'b1, 1'b1);
    rq_go(16'h0030, 32'h0000_0100, 2'd1, 1'b1);
    chk(11, "new entry fault", 32'(rsp_fault), 32'd0);
    chk(11, "new entry lin", rsp_lin, 32'h0000_8100);
    wr(3'd6, 32'h0000_9000, 32'h0000_00FF, 1'b1, 1'b0, 1'b1, 1'b0);
    rq_go(16'h0030, 32'h0000_0100, 2'd1, 1'b0);
    chk(11, "rewritten limit", 32'(rsp_fault), 32'd1);
    rq_go(16'h0030, 32'h0000_0010, 2'd1, 1'b1);
    chk(9, "rewritten user bit", 32'(rsp_fault), 32'd1);
    rq_go(16'h0030, 32'h0000_0010, 2'd1, 1'b0);
    chk(11, "rewritten base", rsp_lin, 32'h0000_9010);
    // R4 zero limit allows offset 0 only
    wr(3'd7, 32'h0000_0040, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    rq_go(16'h0038, 32'h0, 2'd0, 1'b1);
    chk(4, "zero limit offset 0", rsp_lin, 32'h0000_0040);
    rq_go(16'h0038, 32'h1, 2'd0, 1'b1);
    chk(4, "zero limit offset 1", 32'(rsp_fault), 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule